// File: doc/BRIEF.md
# Coarse Quantizer Dither and Polarity Scrambler

This block steers the coarse sub-quantizer of a pipeline converter so that its comparator offsets and threshold errors stop showing up as fixed spurs. Each conversion strobe advances a pseudorandom bit generator. From the new bits the block takes a three-bit code that selects one of five equally likely threshold shifts. The same shift is applied to every comparator of the stage. It also takes one polarity bit. When that bit is set, the analog side swaps both the inputs and the outputs of every comparator.

The block does not subtract the dither, because the later digital error correction cancels it. It does undo the polarity swap. The raw comparator word is registered for one clock. When the swap is active it is bit-reversed and inverted, so downstream logic always sees a normal thermometer code. The analog side maps the five codes onto a programmable span: code 0 is −1/2, code 1 is −1/4, code 2 is 0, code 3 is +1/4 and code 4 is +1/2 of the span.

Top module: `dpr_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block loads its generator state from `seed_i` and sets `thr_sel_o` to 2, `swap_o` to 0 and `therm_fix_o` to all zeros.
- R2: A seed of zero is replaced by the nonzero default 23'h01ACE5, and the generator state is never zero.
- R3: The generator is a 23-bit shift register. It shifts toward the MSB, and the new bit entering bit 0 is bit 22 XOR bit 17 (polynomial x^23+x^18+1). On each clock with `conv_strobe` high it advances exactly 3·MAX_DRAWS+1 shifts (25 by default).
- R4: Attempt k (k = 0 … MAX_DRAWS−1) reads bits [2:0] of the state after 3·(k+1) shifts, with bit 2 as the MSB. The first attempt whose value is below 5 becomes `thr_sel_o` after the strobe edge.
- R5: If no attempt gives a value below 5, `thr_sel_o` becomes 0.
- R6: `swap_o` after a strobe edge equals bit 0 of the state after all 3·MAX_DRAWS+1 shifts. No attempt reads this bit.
- R7: Without a strobe, `thr_sel_o`, `swap_o` and the generator state hold, whatever happens on `therm_raw_i`.
- R8: At each clock edge `therm_fix_o` takes `therm_raw_i` unchanged when `swap_o` is 0. When `swap_o` is 1 it takes the raw word bit-reversed (output bit i = raw bit W−1−i) and inverted.
- R9: `thr_sel_o` only ever holds codes 0 to 4. Codes 5, 6 and 7 never appear.
- R10: Over 20000 conversions from one seed, each of the five codes makes up between 18% and 22% of the total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the seed |
| conv_strobe | input | 1 | One-cycle pulse per conversion; makes a new random choice |
| seed_i | input | 23 | Generator seed, sampled during reset |
| therm_raw_i | input | THERM_W | Raw comparator thermometer outputs |
| thr_sel_o | output | 3 | Threshold shift code, 0..4 |
| swap_o | output | 1 | Comparator input/output polarity swap |
| therm_fix_o | output | THERM_W | Polarity-corrected thermometer code, one cycle after the raw word |

## Verification
The bench keeps its own model of the generator and checks every draw from several seeds. One seed is built by running the generator backwards from an all-ones state, so that every attempt in a conversion is rejected. A design that treated the last attempt as always valid, or that fell back to the centre code, would then give 6 or 2 instead of 0.

Idle stretches with a changing comparator word catch a generator that advances on every clock. Such a design would diverge from the model at the next conversion. The thermometer fix is checked with all-zero, all-one and random words. A version that only inverts without reversing, or that uses the swap value one conversion late, fails on patterns that are not symmetric. A long histogram run exposes a biased mapping, such as a modulo-5 fold.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int LFSR_W   = 23;
  localparam int TAP_HI   = 22;
  localparam int TAP_LO   = 17;
  localparam int SEL_W    = 3;
  localparam int N_LEVELS = 5;
  localparam int SEL_MID  = 2;

  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [SEL_W-1:0]  sel_t;

  localparam lfsr_t SEED_DEFAULT = 23'h01ACE5;

  // one shift of the maximal-length generator
  function automatic lfsr_t lfsr_step(lfsr_t s);
    return {s[LFSR_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
  endfunction

  // a zero seed would lock the generator
  function automatic lfsr_t seed_fix(lfsr_t s);
    return (s == '0) ? SEED_DEFAULT : s;
  endfunction

  function automatic logic sel_legal(sel_t v);
    return v < SEL_W'(N_LEVELS);
  endfunction
endpackage

// File: rtl/dpr_draw.sv
module dpr_draw
  import dpr_pkg::*;
#(
  parameter int MAX_DRAWS = 8
) (
  input  lfsr_t state_i,
  output lfsr_t state_o,
  output sel_t  sel_o,
  output logic  swap_o,
  output logic  fallback_o
);
  localparam int TOTAL = 3 * MAX_DRAWS + 1;

  lfsr_t chain [TOTAL+1];
  sel_t  cand  [MAX_DRAWS];
  logic [MAX_DRAWS-1:0] ok;

  assign chain[0] = state_i;

  generate
    for (genvar i = 1; i <= TOTAL; i++) begin : g_shift
      assign chain[i] = lfsr_step(chain[i-1]);
    end
    for (genvar k = 0; k < MAX_DRAWS; k++) begin : g_try
      assign cand[k] = chain[3*(k+1)][SEL_W-1:0];
      assign ok[k]   = sel_legal(cand[k]);
    end
  endgenerate

  // first legal attempt wins: scan from the last one down
  always_comb begin
    sel_o = '0;
    for (int k = MAX_DRAWS - 1; k >= 0; k--) begin
      if (ok[k]) sel_o = cand[k];
    end
  end

  assign fallback_o = ~|ok;
  assign swap_o     = chain[TOTAL][0];
  assign state_o    = chain[TOTAL];
endmodule

// File: rtl/dpr_therm_fix.sv
module dpr_therm_fix #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         swap_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] fix_o
);
  logic [W-1:0] raw_rev;

  generate
    for (genvar i = 0; i < W; i++) begin : g_rev
      assign raw_rev[i] = raw_i[W-1-i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) fix_o <= '0;
    else        fix_o <= swap_i ? ~raw_rev : raw_i;
  end

  AST_THERM_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    swap_i |=> $countones(fix_o) == W - $countones($past(raw_i))); // R8
endmodule

// File: rtl/dpr_ctrl.sv
module dpr_ctrl
  import dpr_pkg::*;
#(
  parameter int THERM_W   = 32,
  parameter int MAX_DRAWS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               conv_strobe,
  input  logic [22:0]        seed_i,
  input  logic [THERM_W-1:0] therm_raw_i,
  output logic [2:0]         thr_sel_o,
  output logic               swap_o,
  output logic [THERM_W-1:0] therm_fix_o
);
  lfsr_t lfsr_q;
  sel_t  sel_q;
  logic  swap_q;

  lfsr_t draw_next;
  sel_t  draw_sel;
  logic  draw_swap;
  logic  draw_fallback;

  dpr_draw #(.MAX_DRAWS(MAX_DRAWS)) u_draw (
    .state_i   (lfsr_q),
    .state_o   (draw_next),
    .sel_o     (draw_sel),
    .swap_o    (draw_swap),
    .fallback_o(draw_fallback)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q <= seed_fix(seed_i);
      sel_q  <= SEL_W'(SEL_MID);
      swap_q <= 1'b0;
    end else if (conv_strobe) begin
      lfsr_q <= draw_next;
      sel_q  <= draw_sel;
      swap_q <= draw_swap;
    end
  end

  dpr_therm_fix #(.W(THERM_W)) u_fix (
    .clk   (clk),
    .rst_n (rst_n),
    .swap_i(swap_q),
    .raw_i (therm_raw_i),
    .fix_o (therm_fix_o)
  );

  assign thr_sel_o = sel_q;
  assign swap_o    = swap_q;

  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0); // R2
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q < SEL_W'(N_LEVELS)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_strobe |=> $stable(sel_q) && $stable(swap_q) && $stable(lfsr_q)); // R7
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |=> lfsr_q != $past(lfsr_q)); // R3
  AST_FALLBACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe && draw_fallback |=> sel_q == '0); // R5
endmodule

// File: tb/tb_dpr_ctrl.sv
module tb_dpr_ctrl;
  localparam int W  = 32;
  localparam int ND = 8;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         conv_strobe = 0;
  logic [22:0]  seed_i = '0;
  logic [W-1:0] therm_raw_i = '0;
  logic [2:0]   thr_sel_o;
  logic         swap_o;
  logic [W-1:0] therm_fix_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [22:0] m_state;
  int hist [8];

  always #4 clk = ~clk;

  dpr_ctrl #(.THERM_W(W), .MAX_DRAWS(ND)) dut (
    .clk(clk), .rst_n(rst_n), .conv_strobe(conv_strobe), .seed_i(seed_i),
    .therm_raw_i(therm_raw_i), .thr_sel_o(thr_sel_o), .swap_o(swap_o),
    .therm_fix_o(therm_fix_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [22:0] m_fwd(input logic [22:0] s);
    logic nb;
    nb = s[22] ^ s[17];
    return (s << 1) | {22'd0, nb};
  endfunction

  function automatic logic [22:0] m_back(input logic [22:0] s);
    logic [22:0] p;
    p = s >> 1;
    p[22] = s[0] ^ s[18];
    return p;
  endfunction

  // restated draw: walk the shifts, record the first legal triple
  function automatic void m_draw(input logic [22:0] s, output logic [2:0] sel,
                                 output logic sw, output logic fb, output logic [22:0] nxt);
    logic [22:0] t;
    bit found;
    t = s; found = 0; sel = 3'd0;
    for (int n = 1; n <= 3*ND+1; n++) begin
      t = m_fwd(t);
      if (n % 3 == 0 && n <= 3*ND && !found && t[2:0] <= 3'd4) begin
        sel = t[2:0];
        found = 1;
      end
    end
    sw = t[0];
    fb = !found;
    nxt = t;
  endfunction

  function automatic logic [W-1:0] m_fix(input logic [W-1:0] raw, input logic sw);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[W-1-i] = raw[i];
    return sw ? ~r : raw;
  endfunction

  task automatic do_reset(input logic [22:0] seed);
    seed_i = seed;
    @(negedge clk) rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    chk(thr_sel_o == 3'd2, "R1 sel", thr_sel_o, 2);
    chk(swap_o == 1'b0, "R1 swap", swap_o, 0);
    chk(therm_fix_o == '0, "R1 therm", therm_fix_o, 0);
    rst_n = 1;
    m_state = (seed == 0) ? 23'h01ACE5 : seed;
  endtask

  task automatic do_conv(input string req, input logic [W-1:0] raw_pat, input bit use_pat,
                         output logic fb);
    logic [2:0] es;
    logic esw;
    logic [22:0] nx;
    logic [W-1:0] raw;
    @(negedge clk);
    conv_strobe = 1;
    therm_raw_i = $urandom;
    @(negedge clk);
    conv_strobe = 0;
    m_draw(m_state, es, esw, fb, nx);
    m_state = nx;
    chk(thr_sel_o == es, req, thr_sel_o, es);
    chk(swap_o == esw, req, swap_o, esw);
    chk(thr_sel_o <= 3'd4, "R9 range", thr_sel_o, 4);
    hist[thr_sel_o]++;
    raw = use_pat ? raw_pat : W'($urandom);
    therm_raw_i = raw;
    @(negedge clk);
    chk(therm_fix_o == m_fix(raw, esw), "R8 therm", therm_fix_o, m_fix(raw, esw));
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic fb;
    logic [22:0] s;
    logic [2:0] hs;
    logic hsw;
    for (int i = 0; i < 8; i++) hist[i] = 0;

    // R2: zero seed takes the default
    do_reset(23'd0);
    for (int i = 0; i < 20; i++) do_conv("R2 default seed", '0, 0, fb);

    // R3 R4 R6: several seeds against the model
    do_reset(23'h7FFFFF);
    for (int i = 0; i < 40; i++) do_conv("R4 R6 draw", '0, 0, fb);
    do_reset(23'h000001);
    for (int i = 0; i < 40; i++) do_conv("R3 R4 draw", '0, 0, fb);

    // R8 edge patterns under both polarities
    do_reset(23'h2B3C4D);
    for (int i = 0; i < 8; i++) begin
      do_conv("R8 pattern", '0, 1, fb);
      do_conv("R8 pattern", '1, 1, fb);
      do_conv("R8 pattern", 32'h0000_FFFF, 1, fb);
      do_conv("R8 pattern", 32'h0000_0007, 1, fb);
    end

    // R7: idle with changing raw word, then the next draw must still match
    hs = thr_sel_o; hsw = swap_o;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk) therm_raw_i = $urandom;
      chk(thr_sel_o == hs, "R7 hold sel", thr_sel_o, hs);
      chk(swap_o == hsw, "R7 hold swap", swap_o, hsw);
    end
    do_conv("R7 no advance", '0, 0, fb);

    // R5: seed that makes every attempt illegal (all ones after 23 shifts)
    s = '1;
    for (int i = 0; i < 23; i++) s = m_back(s);
    do_reset(s);
    do_conv("R5 fallback", '0, 0, fb);
    chk(fb == 1'b1, "R5 model fallback", fb, 1);
    chk(thr_sel_o == 3'd0, "R5 code zero", thr_sel_o, 0);

    // R10: histogram
    for (int i = 0; i < 8; i++) hist[i] = 0;
    do_reset(23'h3C0F1);
    for (int i = 0; i < 20000; i++) do_conv("R4 long run", '0, 0, fb);
    for (int c = 0; c < 5; c++)
      chk(hist[c] >= 3600 && hist[c] <= 4400, "R10 histogram", hist[c], 4000);
    for (int c = 5; c < 8; c++)
      chk(hist[c] == 0, "R9 illegal code", hist[c], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule